// File: doc/BRIEF.md
# Power Monitor Serial Command and Readback Slave

This block is the two-wire serial slave of a supply monitor. It answers on a 7-bit address whose upper five bits are fixed and whose lower two come from a board strap. It accepts three kinds of write. The first is a bare address used as a presence check. The second is a command byte that sets the conversion controls. The third is a pointer byte followed by a value for one of three alert registers.

Reads return the latest voltage and current results packed into two or three bytes, or a single status byte, depending on the command bits. The clock and data lines are synchronized to the system clock and glitch-filtered before any bus condition is decoded. The data line is driven only as an open-drain pull-low enable.

The command bits and the alert registers go to the conversion sequencer and the alert logic. Results, status and a ready flag come back from them.

Top module: `pmon_i2c_slave`

## Requirements
- R1: The slave address is binary 01011 followed by the two strap bits. In 8-bit form with the direction bit as bit 0, the write frames are therefore 0x58, 0x5A, 0x5C and 0x5E. A matching address is acknowledged by pulling SDA low for the ninth clock.
- R2: A non-matching address is not acknowledged. The slave then leaves SDA released until the next START, so later bytes of that transfer are not acknowledged and change no register.
- R3: A write carrying only the address, followed by STOP, is acknowledged and changes no register.
- R4: The first written byte with bit 7 clear loads its bits 6..0 onto `ctrl_o`.
- R5: A first written byte with bit 7 set is a pointer. Its bits 1..0 select a register: 00 is alert enable, 01 is alert threshold and 10 is control. The following byte is written to that register, and pointer 11 selects none. Any further data bytes in the transfer are acknowledged and ignored.
- R6: With voltage enabled (ctrl bit 0 or 1) and current enabled (ctrl bit 2 or 3), a read returns three bytes. These are voltage bits 11..4, then current bits 11..4, then voltage bits 3..0 in the upper nibble with current bits 3..0 in the lower nibble.
- R7: With one channel enabled, a read returns two bytes: bits 11..4, then bits 3..0 in the upper nibble with the lower nibble zero. If only current is enabled the current result is returned; otherwise the voltage result is returned.
- R8: With ctrl bit 6 set, a read returns the status byte. Every byte read past the end of the active format is 0x00.
- R9: A read address is not acknowledged while ctrl bit 6 is clear and `data_ready_i` is low. With ctrl bit 6 set it is acknowledged regardless of `data_ready_i`.
- R10: The results and the status are captured when the read address is acknowledged, so later input changes do not alter that read. A master acknowledge fetches the next byte. A master not-acknowledge ends the read and releases SDA.
- R11: SCL and SDA pulses shorter than `FILT_LEN` clocks are ignored. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The slave changes SDA only while SCL is low.
- R12: After reset `ctrl_o` is 0x00, alert enable is 0x00, alert threshold is 0xFF, control is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| addr_strap_i | input | 2 | Low two address bits |
| data_ready_i | input | 1 | Conversion results are valid |
| volt_i | input | 12 | Latest voltage result |
| curr_i | input | 12 | Latest current result |
| status_i | input | 8 | Alert status byte |
| ctrl_o | output | 7 | Command bits |
| alert_en_o | output | 8 | Alert enable register |
| alert_th_o | output | 8 | Alert threshold register |
| control_o | output | 8 | Control register |

## Verification
The bench sends a pointer of 11 and expects all three alert registers to keep their values. A decoder that aliased pointer 11 onto a real register would corrupt one of them. A wrong address is followed by a further data byte that must go unacknowledged. A slave that stayed attached would acknowledge that byte and load it as a command. Short SCL and SDA pulses are injected in the middle of a command byte. A filter that was too short would shift in an extra bit or see a false STOP, and `ctrl_o` would then hold the wrong value. Reads run four bytes deep in every channel mode, and the inputs change after the address is acknowledged. Wrong nibble packing, bytes past the end that are not zero, or a live instead of captured result would each show up as a mismatched byte.

// File: rtl/pmon_i2c_pkg.sv
package pmon_i2c_pkg;
  localparam int RES_W    = 12;
  localparam int EXT_REGS = 3;
  localparam int PTR_W    = 2;
  localparam logic [4:0] ADDR_HI = 5'b01011;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RX,
    LK_RX_ACK,
    LK_TX,
    LK_TX_ACK
  } link_state_e;
endpackage

// File: rtl/pmon_glitch_filter.sv
module pmon_glitch_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 4,
  parameter logic RST_VAL     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      // new level must persist FILT_LEN samples before it is taken
      if (sync_q[SYNC_STAGES-1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= sync_q[SYNC_STAGES-1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/pmon_i2c_link.sv
module pmon_i2c_link
  import pmon_i2c_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_strap_i,
  input  logic       rd_ok_i,
  input  logic [7:0] tx_byte_i,
  output logic       sda_pull_o,
  output logic       bus_evt_o,
  output logic       wr_stb_o,
  output logic       wr_first_o,
  output logic [7:0] rx_byte_o,
  output logic       rd_open_o,
  output logic [1:0] rd_idx_o
);
  link_state_e state_q;
  logic       scl_q, sda_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q;
  logic       addr_ph_q, rw_q, ack_q, mack_q, first_q;
  logic       wr_stb_q, wr_first_q, rd_open_q;
  logic [1:0] rd_idx_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] own_addr;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign own_addr  = {ADDR_HI, addr_strap_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= LK_IDLE;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      addr_ph_q  <= 1'b0;
      rw_q       <= 1'b0;
      ack_q      <= 1'b0;
      mack_q     <= 1'b0;
      first_q    <= 1'b0;
      wr_stb_q   <= 1'b0;
      wr_first_q <= 1'b0;
      rd_open_q  <= 1'b0;
      rd_idx_q   <= '0;
    end else begin
      scl_q     <= scl_i;
      sda_q     <= sda_i;
      wr_stb_q  <= 1'b0;
      rd_open_q <= 1'b0;
      if (start_det) begin
        state_q   <= LK_RX;
        bit_cnt_q <= '0;
        addr_ph_q <= 1'b1;
      end else if (stop_det) begin
        state_q <= LK_IDLE;
      end else begin
        unique case (state_q)
          LK_RX: begin
            if (scl_rise && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (addr_ph_q) begin
                if (shreg_q[7:1] == own_addr) begin
                  rw_q      <= shreg_q[0];
                  ack_q     <= ~shreg_q[0] | rd_ok_i;
                  rd_open_q <= shreg_q[0] & rd_ok_i;
                  rd_idx_q  <= '0;
                  first_q   <= 1'b1;
                  state_q   <= LK_RX_ACK;
                end else begin
                  state_q <= LK_IDLE;
                end
              end else begin
                wr_stb_q   <= 1'b1;
                wr_first_q <= first_q;
                first_q    <= 1'b0;
                ack_q      <= 1'b1;
                state_q    <= LK_RX_ACK;
              end
            end
          end
          LK_RX_ACK: begin
            if (scl_fall) begin
              addr_ph_q <= 1'b0;
              bit_cnt_q <= '0;
              if (!ack_q) begin
                state_q <= LK_IDLE;
              end else if (addr_ph_q && rw_q) begin
                state_q  <= LK_TX;
                shreg_q  <= tx_byte_i;
                rd_idx_q <= rd_idx_q + 2'd1;
              end else begin
                state_q <= LK_RX;
              end
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              if (bit_cnt_q == 4'd7) begin
                state_q <= LK_TX_ACK;
              end else begin
                shreg_q   <= {shreg_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          LK_TX_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q   <= LK_TX;
                shreg_q   <= tx_byte_i;
                bit_cnt_q <= '0;
                if (rd_idx_q != 2'd3) rd_idx_q <= rd_idx_q + 2'd1;
              end else begin
                state_q <= LK_IDLE;
              end
            end
          end
          default: state_q <= LK_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_o = (state_q == LK_RX_ACK && ack_q) || (state_q == LK_TX && !shreg_q[7]);
  assign bus_evt_o  = start_det | stop_det;
  assign wr_stb_o   = wr_stb_q;
  assign wr_first_o = wr_first_q;
  assign rx_byte_o  = shreg_q;
  assign rd_open_o  = rd_open_q;
  assign rd_idx_o   = rd_idx_q;
endmodule

// File: rtl/pmon_reg_bank.sv
module pmon_reg_bank
  import pmon_i2c_pkg::*;
#(
  parameter logic [7:0] ALERT_EN_RST = 8'h00,
  parameter logic [7:0] ALERT_TH_RST = 8'hFF,
  parameter logic [7:0] CONTROL_RST  = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic             wr_first_i,
  input  logic [7:0]       wr_byte_i,
  input  logic             rd_open_i,
  input  logic [1:0]       rd_idx_i,
  input  logic             data_ready_i,
  input  logic [RES_W-1:0] volt_i,
  input  logic [RES_W-1:0] curr_i,
  input  logic [7:0]       status_i,
  output logic             rd_ok_o,
  output logic [7:0]       tx_byte_o,
  output logic [6:0]       ctrl_o,
  output logic [7:0]       alert_en_o,
  output logic [7:0]       alert_th_o,
  output logic [7:0]       control_o
);
  localparam logic [8*EXT_REGS-1:0] EXT_RST = {CONTROL_RST, ALERT_TH_RST, ALERT_EN_RST};
  localparam int LO_W = RES_W - 8;

  logic [6:0]       ctrl_q;
  logic [PTR_W-1:0] ptr_q;
  logic             armed_q;
  logic [7:0]       ext_q [EXT_REGS];
  logic [RES_W-1:0] snap_v_q, snap_i_q;
  logic [7:0]       snap_s_q;
  logic             v_en, i_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ptr_q    <= '0;
      armed_q  <= 1'b0;
      snap_v_q <= '0;
      snap_i_q <= '0;
      snap_s_q <= '0;
    end else begin
      if (wr_stb_i) begin
        if (wr_first_i && !wr_byte_i[7]) begin
          ctrl_q  <= wr_byte_i[6:0];
          armed_q <= 1'b0;
        end else if (wr_first_i) begin
          ptr_q   <= wr_byte_i[PTR_W-1:0];
          armed_q <= 1'b1;
        end else begin
          armed_q <= 1'b0;
        end
      end
      if (rd_open_i) begin
        snap_v_q <= volt_i;
        snap_i_q <= curr_i;
        snap_s_q <= status_i;
      end
    end
  end

  for (genvar g = 0; g < EXT_REGS; g++) begin : g_ext
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ext_q[g] <= EXT_RST[g*8 +: 8];
      end else if (wr_stb_i && !wr_first_i && armed_q && ptr_q == PTR_W'(g)) begin
        ext_q[g] <= wr_byte_i;
      end
    end
  end

  assign v_en = ctrl_q[0] | ctrl_q[1];
  assign i_en = ctrl_q[2] | ctrl_q[3];

  always_comb begin
    tx_byte_o = 8'h00;
    if (ctrl_q[6]) begin
      if (rd_idx_i == 2'd0) tx_byte_o = snap_s_q;
    end else if (v_en && i_en) begin
      unique case (rd_idx_i)
        2'd0:    tx_byte_o = snap_v_q[RES_W-1 -: 8];
        2'd1:    tx_byte_o = snap_i_q[RES_W-1 -: 8];
        2'd2:    tx_byte_o = {snap_v_q[LO_W-1:0], snap_i_q[LO_W-1:0]};
        default: tx_byte_o = 8'h00;
      endcase
    end else if (i_en) begin
      if (rd_idx_i == 2'd0)      tx_byte_o = snap_i_q[RES_W-1 -: 8];
      else if (rd_idx_i == 2'd1) tx_byte_o = {snap_i_q[LO_W-1:0], {(8-LO_W){1'b0}}};
    end else begin
      if (rd_idx_i == 2'd0)      tx_byte_o = snap_v_q[RES_W-1 -: 8];
      else if (rd_idx_i == 2'd1) tx_byte_o = {snap_v_q[LO_W-1:0], {(8-LO_W){1'b0}}};
    end
  end

  assign rd_ok_o    = ctrl_q[6] | data_ready_i;
  assign ctrl_o     = ctrl_q;
  assign alert_en_o = ext_q[0];
  assign alert_th_o = ext_q[1];
  assign control_o  = ext_q[2];
endmodule

// File: rtl/pmon_i2c_slave.sv
module pmon_i2c_slave
  import pmon_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES  = 2,
  parameter int         FILT_LEN     = 4,
  parameter logic [7:0] ALERT_EN_RST = 8'h00,
  parameter logic [7:0] ALERT_TH_RST = 8'hFF,
  parameter logic [7:0] CONTROL_RST  = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [1:0]       addr_strap_i,
  input  logic             data_ready_i,
  input  logic [RES_W-1:0] volt_i,
  input  logic [RES_W-1:0] curr_i,
  input  logic [7:0]       status_i,
  output logic [6:0]       ctrl_o,
  output logic [7:0]       alert_en_o,
  output logic [7:0]       alert_th_o,
  output logic [7:0]       control_o
);
  logic [1:0] line_raw, line_f;
  logic       bus_evt, wr_stb, wr_first, rd_open, rd_ok;
  logic [7:0] rx_byte, tx_byte;
  logic [1:0] rd_idx;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    pmon_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .RST_VAL    (1'b1)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(line_raw[g]),
      .line_o(line_f[g])
    );
  end

  pmon_i2c_link u_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (line_f[1]),
    .sda_i       (line_f[0]),
    .addr_strap_i(addr_strap_i),
    .rd_ok_i     (rd_ok),
    .tx_byte_i   (tx_byte),
    .sda_pull_o  (sda_pull_o),
    .bus_evt_o   (bus_evt),
    .wr_stb_o    (wr_stb),
    .wr_first_o  (wr_first),
    .rx_byte_o   (rx_byte),
    .rd_open_o   (rd_open),
    .rd_idx_o    (rd_idx)
  );

  pmon_reg_bank #(
    .ALERT_EN_RST(ALERT_EN_RST),
    .ALERT_TH_RST(ALERT_TH_RST),
    .CONTROL_RST (CONTROL_RST)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_stb_i    (wr_stb),
    .wr_first_i  (wr_first),
    .wr_byte_i   (rx_byte),
    .rd_open_i   (rd_open),
    .rd_idx_i    (rd_idx),
    .data_ready_i(data_ready_i),
    .volt_i      (volt_i),
    .curr_i      (curr_i),
    .status_i    (status_i),
    .rd_ok_o     (rd_ok),
    .tx_byte_o   (tx_byte),
    .ctrl_o      (ctrl_o),
    .alert_en_o  (alert_en_o),
    .alert_th_o  (alert_th_o),
    .control_o   (control_o)
  );
endmodule

// File: rtl/pmon_i2c_slave_chk.sv
module pmon_i2c_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_f_i,
  input logic        bus_evt_i,
  input logic        sda_pull_i,
  input logic        wr_stb_i,
  input logic        wr_first_i,
  input logic [6:0]  ctrl_i,
  input logic [23:0] ext_i
);
  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f_i && $past(scl_f_i) && !$past(bus_evt_i)) |-> $stable(sda_pull_i)); // R11

  AST_RELEASE_AFTER_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_evt_i) |-> !sda_pull_i); // R10

  AST_CTRL_ONLY_BY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_i) |-> $past(wr_stb_i && wr_first_i)); // R4

  AST_EXT_ONLY_BY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ext_i) |-> $past(wr_stb_i && !wr_first_i)); // R5
endmodule

bind pmon_i2c_slave pmon_i2c_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_f_i   (line_f[1]),
  .bus_evt_i (bus_evt),
  .sda_pull_i(sda_pull_o),
  .wr_stb_i  (wr_stb),
  .wr_first_i(wr_first),
  .ctrl_i    (ctrl_o),
  .ext_i     ({alert_en_o, alert_th_o, control_o})
);

// File: tb/pmon_i2c_slave_tb_top.sv
module pmon_i2c_slave_tb_top;
  localparam int Q = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda_low = 1'b0;
  logic        sda_line;
  logic        sda_pull_o;
  logic [1:0]  strap = 2'd2;
  logic        ready = 1'b1;
  logic [11:0] volt = '0, curr = '0;
  logic [7:0]  stat = '0;
  logic [6:0]  ctrl_o;
  logic [7:0]  alert_en_o, alert_th_o, control_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rb [4];

  always #10 clk_i = ~clk_i;
  assign sda_line = ~(m_sda_low | sda_pull_o);

  pmon_i2c_slave dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .addr_strap_i(strap), .data_ready_i(ready),
    .volt_i(volt), .curr_i(curr), .status_i(stat), .ctrl_o(ctrl_o),
    .alert_en_o(alert_en_o), .alert_th_o(alert_th_o), .control_o(control_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk_i);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda_low = 1'b1; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda_low = 1'b0; qw();
  endtask

  task automatic wr_bit(input logic b);
    m_sda_low = ~b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic rd_bit(output logic b);
    m_sda_low = 1'b0; qw(); m_scl = 1'b1; qw(); b = sda_line; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int k = 7; k >= 0; k--) wr_bit(d[k]);
    rd_bit(a);
    ack = ~a;
  endtask

  // bit 4 carries a short SCL pulse in its low phase, bit 2 a short SDA dip in its high phase
  task automatic send_byte_glitch(input logic [7:0] d, output logic ack);
    logic a;
    for (int k = 7; k >= 0; k--) begin
      m_sda_low = ~d[k]; qw();
      if (k == 4) begin
        m_scl = 1'b1; repeat (2) @(negedge clk_i); m_scl = 1'b0; qw();
      end
      m_scl = 1'b1; qw();
      if (k == 2 && d[k]) begin
        m_sda_low = 1'b1; repeat (2) @(negedge clk_i); m_sda_low = 1'b0;
      end
      qw(); m_scl = 1'b0; qw();
    end
    rd_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int k = 7; k >= 0; k--) rd_bit(d[k]);
    wr_bit(~give_ack);
  endtask

  function automatic logic [7:0] addr8(input logic [1:0] s, input logic rw);
    return {5'b01011, s, rw};
  endfunction

  task automatic wr_txn(input logic [7:0] b0, input logic [7:0] b1, input int nb,
                        output logic a0, output logic a1, output logic a2);
    bus_start();
    send_byte(addr8(strap, 1'b0), a0);
    a1 = 1'b0; a2 = 1'b0;
    if (nb > 0) send_byte(b0, a1);
    if (nb > 1) send_byte(b1, a2);
    bus_stop();
  endtask

  task automatic rd_txn(input int n, output logic aack);
    bus_start();
    send_byte(addr8(strap, 1'b1), aack);
    if (aack) for (int k = 0; k < n; k++) recv_byte(k != n - 1, rb[k]);
    bus_stop();
  endtask

  function automatic logic [7:0] exp_byte(input logic [6:0] c, input logic [11:0] v,
      input logic [11:0] i, input logic [7:0] s, input int k);
    logic ve, ie;
    ve = c[0] | c[1];
    ie = c[2] | c[3];
    if (c[6]) return (k == 0) ? s : 8'h00;
    if (ve && ie) begin
      if (k == 0) return v[11:4];
      if (k == 1) return i[11:4];
      if (k == 2) return {v[3:0], i[3:0]};
      return 8'h00;
    end
    if (ie) begin
      if (k == 0) return i[11:4];
      if (k == 1) return {i[3:0], 4'h0};
      return 8'h00;
    end
    if (k == 0) return v[11:4];
    if (k == 1) return {v[3:0], 4'h0};
    return 8'h00;
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] b;
    logic [6:0] c;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R12 reset state
    chk("R12 ctrl", ctrl_o, 7'h00);
    chk("R12 alert_en", alert_en_o, 8'h00);
    chk("R12 alert_th", alert_th_o, 8'hFF);
    chk("R12 control", control_o, 8'h00);
    chk("R12 sda", sda_pull_o, 1'b0);

    // R1 / R3 each strap, presence check; R2 neighbour address not acked
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      bus_start(); send_byte(addr8(strap, 1'b0), a0); bus_stop();
      chk("R1 strap ack", a0, 1'b1);
      bus_start(); send_byte(addr8(strap ^ 2'd1, 1'b0), a0); bus_stop();
      chk("R2 other strap nack", a0, 1'b0);
    end
    chk("R3 ctrl after presence", ctrl_o, 7'h00);
    chk("R3 thresh after presence", alert_th_o, 8'hFF);
    strap = 2'd2;

    // R2 foreign address then data byte
    bus_start(); send_byte(8'hA0, a0); send_byte(8'h05, a1); bus_stop();
    chk("R2 foreign addr nack", a0, 1'b0);
    chk("R2 detached byte nack", a1, 1'b0);
    chk("R2 ctrl untouched", ctrl_o, 7'h00);

    // R4 command; R5 extra byte ignored
    wr_txn(8'h05, 8'h00, 1, a0, a1, a2);
    chk("R4 cmd ack", a1, 1'b1);
    chk("R4 ctrl load", ctrl_o, 7'h05);
    wr_txn(8'h0C, 8'h7F, 2, a0, a1, a2);
    chk("R5 extra byte ack", a2, 1'b1);
    chk("R5 extra byte ignored", ctrl_o, 7'h0C);

    // R5 extended registers
    wr_txn(8'h80, 8'h1B, 2, a0, a1, a2);
    chk("R5 ptr ack", a1, 1'b1);
    chk("R5 alert_en", alert_en_o, 8'h1B);
    wr_txn(8'h81, 8'h40, 2, a0, a1, a2);
    chk("R5 alert_th", alert_th_o, 8'h40);
    wr_txn(8'h82, 8'h01, 2, a0, a1, a2);
    chk("R5 control", control_o, 8'h01);
    wr_txn(8'h83, 8'h99, 2, a0, a1, a2);
    chk("R5 ptr3 en", alert_en_o, 8'h1B);
    chk("R5 ptr3 th", alert_th_o, 8'h40);
    chk("R5 ptr3 ctl", control_o, 8'h01);
    bus_start(); send_byte(addr8(strap, 1'b0), a0); send_byte(8'h81, a1);
    send_byte(8'h22, a1); send_byte(8'h33, a2); bus_stop();
    chk("R5 third byte ignored", alert_th_o, 8'h22);
    chk("R4 ctrl kept by ptr", ctrl_o, 7'h0C);

    // R11 glitches on both lines inside a command byte
    bus_start(); send_byte(addr8(strap, 1'b0), a0); send_byte_glitch(8'h37, a1); bus_stop();
    chk("R11 glitch ack", a1, 1'b1);
    chk("R11 glitch rejected", ctrl_o, 7'h37);

    // R9 not ready
    wr_txn(8'h01, 8'h00, 1, a0, a1, a2);
    ready = 1'b0;
    rd_txn(2, a0);
    chk("R9 read nack not ready", a0, 1'b0);
    ready = 1'b1;
    volt = 12'hABC;
    rd_txn(2, a0);
    chk("R9 read ack ready", a0, 1'b1);
    chk("R7 volt hi", rb[0], 8'hAB);
    chk("R7 volt lo", rb[1], 8'hC0);

    // R10 snapshot and R6 packing, repeated start after command
    curr = 12'h123;
    bus_start(); send_byte(addr8(strap, 1'b0), a0); send_byte(8'h05, a1);
    bus_start(); send_byte(addr8(strap, 1'b1), a0);
    recv_byte(1'b1, rb[0]);
    volt = 12'h000; curr = 12'hFFF;
    recv_byte(1'b1, rb[1]); recv_byte(1'b0, rb[2]); bus_stop();
    chk("R6 byte0", rb[0], 8'hAB);
    chk("R10 snapshot byte1", rb[1], 8'h12);
    chk("R10 snapshot byte2", rb[2], 8'hC3);
    chk("R10 released after nack", sda_pull_o, 1'b0);

    // R8 status, and R9 status ignores ready
    stat = 8'h5A; ready = 1'b0;
    wr_txn(8'h40, 8'h00, 1, a0, a1, a2);
    rd_txn(2, a0);
    chk("R9 status ack", a0, 1'b1);
    chk("R8 status byte", rb[0], 8'h5A);
    chk("R8 past end zero", rb[1], 8'h00);
    ready = 1'b1;

    // random modes
    for (int it = 0; it < 16; it++) begin
      c = 7'($urandom);
      if (($urandom % 4) != 0) c[6] = 1'b0;
      volt = 12'($urandom); curr = 12'($urandom); stat = 8'($urandom);
      wr_txn({1'b0, c}, 8'h00, 1, a0, a1, a2);
      rd_txn(4, a0);
      chk("R4 random ctrl", ctrl_o, c);
      for (int k = 0; k < 4; k++) begin
        b = exp_byte(c, volt, curr, stat, k);
        if (c[6]) chk("R8 random", rb[k], b);
        else if ((c[0] | c[1]) && (c[2] | c[3])) chk("R6 random", rb[k], b);
        else chk("R7 random", rb[k], b);
      end
    end

    done = 1;
    report();
  end
endmodule